// File: doc/BRIEF.md
# Configuration Commit Handshake Target

This block is the hardware end of a configuration-commit protocol. Software reaches it through a small word-addressed register window of 27 words, each 32 bits wide, at byte offsets 0x00 through 0x68. Most words are plain storage that holds configuration payload.

Two words have a role in the protocol:

- **Command word.** It carries a root-enable control. It also carries a busy indication, which software polls until the block reports that it is ready.
- **Commit word.** It sits 0x60 above the command word. Software writes a configuration-entry number into the low byte. It then ORs in a trigger bit. After a fixed latency the block answers with a one-hot acknowledge in the upper half-word, one bit per entry.

Neither the request nor the acknowledge clears by itself. Software closes the exchange by writing the whole commit word to zero. The acknowledge then drops after the same latency.

An entry number that has no acknowledge bit (16 or above) completes without an acknowledge and sets a sticky error flag instead. The acknowledge vector and the error flag are also brought out as ports for neighbouring logic.

Top module: `cfg_commit_target`

## Requirements
- R1: After reset the acknowledge vector and the error flag are 0, the command word reads 0x00000001 (busy set, root-enable clear), the commit word reads 0, every storage word reads 0, and the read data is 0.
- R2: The bus address is a word index (byte offset divided by 4). Words 1..23 and 25..26 store and return any 32-bit value. Writes to indexes above 26 are ignored, and reads there return 0.
- R3: Read data is registered. It takes the addressed word's value at the clock edge that samples a read, and holds that value on all other cycles, including cycles with writes.
- R4: The command word is index 0. Bit 1 is root-enable (read/write), bit 0 is busy (read-only), and bit 2 is the error flag (read-only).
  - Busy is 1 whenever root-enable is 0.
  - Writing root-enable 1 while it is 0 clears busy exactly LAT cycles after the write edge.
  - Writing root-enable 0 sets busy at that edge.
- R5: The commit word is index 24. Any nonzero write stores bits 7:0 as the entry number and bit 8 as the trigger. The other written bits are ignored. The word reads as {ack[15:0], 7'b0, trigger, entry[7:0]}.
- R6: A write that sets the trigger while the stored trigger is 0 and no exchange is open starts an update. For an entry n below 16, acknowledge bit n (commit word bit 16+n) is set exactly LAT cycles after that write edge, and no other acknowledge bit is set.
- R7: Once set, the acknowledge and the stored request fields keep their value until software writes the commit word to zero.
- R8: A write of all zeros to the commit word clears the entry and the trigger at that edge. The acknowledge then reads 0 exactly LAT cycles later. A zero write made before the acknowledge appears cancels the update, and no acknowledge bit is ever set.
- R9: An update for an entry of 16 or above sets no acknowledge bit. It sets the error flag LAT cycles after the trigger write, and only reset clears the flag.
- R10: A trigger written while the acknowledge is still dropping after a zero write starts no update. The request stays stored, and the acknowledge stays 0 until the next zero write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access request for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 6 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ack_vec | output | 16 | One-hot acknowledge, one bit per entry |
| entry_err | output | 1 | Sticky error flag for out-of-range entries |

## Verification
The assertions check the following on every cycle:
- The acknowledge is one-hot or zero, and it is zero whenever no exchange is open.
- The acknowledge stays constant while an exchange is held.
- The error flag never falls.
- Busy is always set while root-enable is clear.
- Read data holds on non-read cycles and is zero for out-of-range reads.

Only the bench scenarios can show the following:
- The exact LAT-cycle spacing of the acknowledge rise and fall, and of the busy release.
- That an entry write without the trigger starts nothing.
- That a zero write cancels a pending update.
- That a trigger written during the drop is ignored.
- That storage words keep randomly written values.

// File: rtl/cfg_commit_pkg.sv
package cfg_commit_pkg;

  // Phase of the commit exchange
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RISE = 2'd1,
    ENG_HELD = 2'd2,
    ENG_FALL = 2'd3
  } eng_state_e;

  // Distance in bytes from the command word to the commit word
  localparam int COMMIT_REL_OFS = 'h60;

endpackage

// File: rtl/cfg_word_store.sv
module cfg_word_store #(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 6,
  parameter int NUM_WORDS = 27,
  parameter int SKIP_A    = 0,
  parameter int SKIP_B    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == SKIP_A || i == SKIP_B) begin : g_hole
      assign words[i] = '0;
    end else begin : g_reg
      logic              sel;
      logic [DATA_W-1:0] q;

      assign sel = wr_en && (idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (sel) begin
          q <= wdata;
        end
      end

      assign words[i] = q;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (idx == IDX_W'(i)) begin
        rd_word = words[i];
      end
    end
  end

endmodule

// File: rtl/cfg_root_ctrl.sv
module cfg_root_ctrl #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic root_wdata,
  output logic root_q,
  output logic busy_q
);

  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             root_d, busy_d;

  always_comb begin
    root_d = root_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
      end
    end
    if (cmd_wr) begin
      root_d = root_wdata;
      if (!root_wdata) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end else if (!root_q) begin
        cnt_d = CNT_LOAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= 1'b0;
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      root_q <= root_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // R4: a disabled root always reports busy
  p_busy_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !root_q |-> busy_q);

  // R4: the final countdown step releases busy
  p_busy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && !cmd_wr) |=> !busy_q);

endmodule

// File: rtl/cfg_ack_engine.sv
module cfg_ack_engine
  import cfg_commit_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENTRY_W = 8,
  parameter int ACK_W   = 16,
  parameter int LAT     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [ENTRY_W-1:0] entry_q,
  output logic               trig_q,
  output logic [ACK_W-1:0]   ack_q,
  output logic               err_q
);

  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CNT_W-1:0]   CNT_LOAD  = CNT_W'(LAT - 1);
  localparam logic [ENTRY_W-1:0] ENTRY_LIM = ENTRY_W'(ACK_W);

  eng_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ENTRY_W-1:0] tgt_q, tgt_d, entry_d;
  logic [ACK_W-1:0]   ack_d;
  logic               trig_d, err_d;
  logic               zero_wr, fill_wr, start;

  assign zero_wr = cfg_wr && (wdata == '0);
  assign fill_wr = cfg_wr && (wdata != '0);
  assign start   = fill_wr && wdata[ENTRY_W] && !trig_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tgt_d   = tgt_q;
    ack_d   = ack_q;
    err_d   = err_q;
    entry_d = entry_q;
    trig_d  = trig_q;

    if (zero_wr) begin
      entry_d = '0;
      trig_d  = 1'b0;
    end else if (fill_wr) begin
      entry_d = wdata[ENTRY_W-1:0];
      trig_d  = wdata[ENTRY_W];
    end

    unique case (state_q)
      ENG_IDLE: begin
        if (start) begin
          state_d = ENG_RISE;
          cnt_d   = CNT_LOAD;
          tgt_d   = wdata[ENTRY_W-1:0];
        end
      end
      ENG_RISE: begin
        if (zero_wr) begin
          state_d = ENG_FALL;
          cnt_d   = CNT_LOAD;
        end else if (cnt_q == '0) begin
          state_d = ENG_HELD;
          if (tgt_q < ENTRY_LIM) begin
            ack_d = ACK_W'(1) << tgt_q;
          end else begin
            err_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ENG_HELD: begin
        if (zero_wr) begin
          state_d = ENG_FALL;
          cnt_d   = CNT_LOAD;
        end
      end
      ENG_FALL: begin
        if (cnt_q == '0) begin
          state_d = ENG_IDLE;
          ack_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
      ack_q   <= '0;
      err_q   <= 1'b0;
      entry_q <= '0;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tgt_q   <= tgt_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
      entry_q <= entry_d;
      trig_q  <= trig_d;
    end
  end

  // R6: never more than one acknowledge bit
  p_ack_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q));

  // R7: a held exchange keeps its acknowledge until a zero write
  p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_HELD && !zero_wr) |=> $stable(ack_q));

  // R8: no acknowledge outside an open exchange
  p_idle_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_IDLE) |-> (ack_q == '0));

  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R9: an entry without an acknowledge bit completes with none set
  p_bad_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_RISE && cnt_q == '0 && !zero_wr && tgt_q >= ENTRY_LIM)
      |=> (ack_q == '0));

endmodule

// File: rtl/cfg_commit_target.sv
module cfg_commit_target
  import cfg_commit_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 6,
  parameter int LAST_OFS = 'h68,
  parameter int CMD_OFS  = 'h00,
  parameter int ENTRY_W  = 8,
  parameter int ACK_W    = 16,
  parameter int LAT      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [IDX_W-1:0]  bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [ACK_W-1:0]  ack_vec,
  output logic              entry_err
);

  localparam int NUM_WORDS = LAST_OFS / 4 + 1;
  localparam int CMD_I     = CMD_OFS / 4;
  localparam int CFG_I     = (CMD_OFS + COMMIT_REL_OFS) / 4;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
  localparam logic [IDX_W-1:0] CMD_IDX  = IDX_W'(CMD_I);
  localparam logic [IDX_W-1:0] CFG_IDX  = IDX_W'(CFG_I);
  localparam int PAD_W = DATA_W - ACK_W - 1 - ENTRY_W;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // Access decode
  logic wr_en, rd_en, in_range, cmd_wr, cfg_wr, store_wr;

  assign wr_en    = bus_valid && bus_write;
  assign rd_en    = bus_valid && !bus_write;
  assign in_range = (bus_word <= LAST_IDX);
  assign cmd_wr   = wr_en && (bus_word == CMD_IDX);
  assign cfg_wr   = wr_en && (bus_word == CFG_IDX);
  assign store_wr = wr_en && in_range;

  logic [DATA_W-1:0]  store_word;
  logic               root_q, busy_q, trig_q, err_q;
  logic [ENTRY_W-1:0] entry_q;
  logic [ACK_W-1:0]   ack_q;

  cfg_word_store #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_WORDS(NUM_WORDS),
    .SKIP_A(CMD_I), .SKIP_B(CFG_I)
  ) u_store (
    .clk(clk), .rst_n(rst_int_n), .wr_en(store_wr), .idx(bus_word),
    .wdata(bus_wdata), .rd_word(store_word)
  );

  cfg_root_ctrl #(.LAT(LAT)) u_root (
    .clk(clk), .rst_n(rst_int_n), .cmd_wr(cmd_wr), .root_wdata(bus_wdata[1]),
    .root_q(root_q), .busy_q(busy_q)
  );

  cfg_ack_engine #(
    .DATA_W(DATA_W), .ENTRY_W(ENTRY_W), .ACK_W(ACK_W), .LAT(LAT)
  ) u_engine (
    .clk(clk), .rst_n(rst_int_n), .cfg_wr(cfg_wr), .wdata(bus_wdata),
    .entry_q(entry_q), .trig_q(trig_q), .ack_q(ack_q), .err_q(err_q)
  );

  // Read mux and registered read data
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (bus_word == CMD_IDX) begin
      rd_val = DATA_W'({err_q, root_q, busy_q});
    end else if (bus_word == CFG_IDX) begin
      rd_val = {ack_q, {(PAD_W){1'b0}}, trig_q, entry_q};
    end else if (in_range) begin
      rd_val = store_word;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      bus_rdata <= rd_val;
    end
  end

  assign ack_vec   = ack_q;
  assign entry_err = err_q;

  // R3: read data only moves on a read
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_en |=> $stable(bus_rdata));

  // R2: reads past the window return zero
  p_oob_zero_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && !in_range) |=> (bus_rdata == '0));

endmodule

// File: tb/cfg_commit_target_test.sv
`timescale 1ns/1ps
module cfg_commit_target_test;

  localparam int LAT     = 4;
  localparam int CMD_W   = 0;
  localparam int CFG_W   = 24;
  localparam int LAST_W  = 26;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [5:0]  bus_word;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] ack_vec;
  logic        entry_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  bit exp_err = 0;
  logic [31:0] model [27];

  cfg_commit_target #(.LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_vec(ack_vec), .entry_err(entry_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_word = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_word = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] exp_ack(input int n);
    return (n < 16) ? (16'd1 << n) : 16'd0;
  endfunction

  function automatic logic [31:0] exp_cfg(input int n, input bit trig);
    return {exp_ack(n), 7'd0, trig, 8'(n)};
  endfunction

  function automatic logic [31:0] exp_store(input int idx);
    return (idx <= LAST_W) ? model[idx] : 32'd0;
  endfunction

  // Full exchange for entry n, with optional junk in ignored bits
  task automatic exchange(input int n, input logic [31:0] junk);
    logic [31:0] v;
    wr(6'(CFG_W), 32'(n));
    repeat (LAT + 1) @(negedge clk);
    chk("R5 entry alone starts nothing", {16'd0, ack_vec}, 32'd0);
    wr(6'(CFG_W), 32'(n) | 32'h100 | junk);
    chk("R6 no ack at write", {16'd0, ack_vec}, 32'd0);
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk);
      chk("R6 no ack before latency", {16'd0, ack_vec}, 32'd0);
    end
    @(negedge clk);
    if (n >= 16) exp_err = 1'b1;
    chk("R6 ack after latency", {16'd0, ack_vec}, {16'd0, exp_ack(n)});
    chk("R9 error flag", {31'd0, entry_err}, {31'd0, exp_err});
    rd(6'(CFG_W), v);
    chk("R5 commit word layout", v, exp_cfg(n, 1'b1));
    repeat ($urandom_range(0, 10)) @(negedge clk);
    chk("R7 ack held", {16'd0, ack_vec}, {16'd0, exp_ack(n)});
    wr(6'(CFG_W), 32'd0);
    for (int k = 0; k < LAT; k++) begin
      chk("R8 ack held before drop", {16'd0, ack_vec}, {16'd0, exp_ack(n)});
      if (k < LAT - 1) @(negedge clk);
    end
    @(negedge clk);
    chk("R8 ack dropped", {16'd0, ack_vec}, 32'd0);
    rd(6'(CFG_W), v);
    chk("R8 commit word cleared", v, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0c1a));
    for (int i = 0; i < 27; i++) model[i] = 32'd0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_word = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'd0);
    chk("R1 ack", {16'd0, ack_vec}, 32'd0);
    chk("R1 err", {31'd0, entry_err}, 32'd0);
    rd(6'(CMD_W), v);  chk("R1 command word", v, 32'h1);
    rd(6'(CFG_W), v);  chk("R1 commit word", v, 32'h0);
    rd(6'd1, v);       chk("R1 storage word", v, 32'h0);

    // R4 root-enable / busy
    wr(6'(CMD_W), 32'h2);
    rd(6'(CMD_W), v);  chk("R4 busy still set", v, 32'h3);
    repeat (LAT) @(negedge clk);
    rd(6'(CMD_W), v);  chk("R4 busy released", v, 32'h2);
    wr(6'(CMD_W), 32'h0);
    rd(6'(CMD_W), v);  chk("R4 disable sets busy", v, 32'h1);
    wr(6'(CMD_W), 32'h2);
    repeat (LAT + 2) @(negedge clk);
    rd(6'(CMD_W), v);  chk("R4 ready again", v, 32'h2);

    // R2 window edges
    wr(6'(LAST_W), 32'hCAFE_0068); model[LAST_W] = 32'hCAFE_0068;
    wr(6'd27, 32'hDEAD_006C);
    wr(6'd63, 32'hDEAD_00FC);
    rd(6'(LAST_W), v); chk("R2 last word", v, 32'hCAFE_0068);
    rd(6'd27, v);      chk("R2 past window", v, 32'h0);
    rd(6'd63, v);      chk("R2 top index", v, 32'h0);

    // R3 read data hold
    wr(6'd1, 32'h1122_3344); model[1] = 32'h1122_3344;
    rd(6'd1, v);       chk("R3 read", v, 32'h1122_3344);
    wr(6'd1, 32'h0000_0055); model[1] = 32'h0000_0055;
    repeat (3) @(negedge clk);
    chk("R3 rdata held across write", bus_rdata, 32'h1122_3344);
    rd(6'd1, v);       chk("R3 new read", v, 32'h0000_0055);

    // R6/R7/R8 directed exchanges at entry edges
    exchange(0, 32'h0);
    exchange(15, 32'hABCD_0600);
    exchange(16, 32'h0);
    chk("R9 sticky after close", {31'd0, entry_err}, 32'd1);

    // R8 cancel before acknowledge
    wr(6'(CFG_W), 32'd3);
    wr(6'(CFG_W), 32'h103);
    wr(6'(CFG_W), 32'd0);
    for (int k = 0; k < 2 * LAT; k++) begin
      @(negedge clk);
      chk("R8 cancelled update", {16'd0, ack_vec}, 32'd0);
    end
    exchange(7, 32'h0);

    // R10 trigger during drop is ignored
    wr(6'(CFG_W), 32'd2);
    wr(6'(CFG_W), 32'h102);
    repeat (LAT + 1) @(negedge clk);
    chk("R6 ack entry 2", {16'd0, ack_vec}, 32'h4);
    wr(6'(CFG_W), 32'd0);
    wr(6'(CFG_W), 32'h105);
    repeat (LAT) @(negedge clk);
    chk("R10 ack dropped", {16'd0, ack_vec}, 32'd0);
    repeat (2 * LAT) @(negedge clk);
    chk("R10 no new ack", {16'd0, ack_vec}, 32'd0);
    rd(6'(CFG_W), v);  chk("R10 request stored", v, 32'h105);
    wr(6'(CFG_W), 32'd0);
    repeat (LAT + 1) @(negedge clk);
    exchange(9, 32'h0);

    // Random storage traffic (R2, R3)
    for (int i = 0; i < 200; i++) begin
      int idx;
      idx = $urandom_range(0, 63);
      if (idx == CMD_W || idx == CFG_W) idx = 1;
      if ($urandom_range(0, 1) == 1) begin
        logic [31:0] d;
        d = $urandom;
        wr(6'(idx), d);
        if (idx <= LAST_W) model[idx] = d;
      end else begin
        rd(6'(idx), v);
        chk("R2 random read", v, exp_store(idx));
      end
    end

    // Random exchanges (R6..R9)
    for (int i = 0; i < 20; i++) begin
      exchange($urandom_range(0, 23), 32'h0);
    end
    rd(6'(CMD_W), v);  chk("R4 R9 command word at end", v, {29'd0, exp_err, 2'b10});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule